// File: doc/BRIEF.md
# Configuration-Memory Test Access Port with Reconfiguration Pulse

This block is the boundary-scan test access port of a configuration memory device. A 16-state controller advances on each rising edge of the test clock. The next state depends on the mode-select input. An 8-bit instruction register picks which data register sits between the serial input and the serial output. Three data registers are available: a one-bit bypass stage, a 32-bit identification code and a 32-bit user code.

When an instruction scan starts, the instruction register captures a status pattern. Two of its bits carry the live ISP-mode flag and the live read-protection flag, so a test host can read the device condition without a separate data scan. The decoder also drives two output-control lines, one to float all outputs and one to clamp them.

A vendor opcode requests a reconfiguration of the attached FPGA. The request crosses into a free-running system clock domain. There it produces an active-low pulse of fixed length on `cf_n`, which is wired to the FPGA program input. Boundary-scan cells and flash programming sit outside this block.

Top module: `cfgprom_tap`

## Requirements
- R1: The controller state changes on each rising `tck` edge according to `tms`. Five consecutive rising edges with `tms` high reach the reset state from any state.
- R2: While the controller is in the reset state, the current instruction becomes IDCODE. A data scan made without a prior instruction scan then returns the identification code, and `highz_en` and `clamp_en` are low.
- R3: The instruction register is 8 bits wide and shifts with the LSB nearest `tdo`. On capture it loads the following pattern: bits 7:5 = 000, bit 4 = `isp_active`, bit 3 = `secure_flag`, bit 2 = 0, bits 1:0 = 01.
- R4: The following opcodes are decoded:
  - 8'hFE (IDCODE) selects the identification register.
  - 8'hFD (USERCODE) selects the user-code register.
  - 8'hFF (BYPASS), 8'h00 (EXTEST), 8'h01 (SAMPLE/PRELOAD), 8'hFA (CLAMP), 8'hFC (HIGHZ), 8'hEE (CONFIG) and every other value select the bypass stage.
- R5: The bypass stage captures 0 and delays `tdi` by one shift, so the first bit out is 0.
- R6: The identification scan returns `IDCODE_VAL` LSB first, with bit 0 forced to 1. The fields are version [31:28], family [27:20], product [19:12] and vendor [11:1].
- R7: The user-code scan returns the value on `usercode_val` as sampled on entry to Capture-DR, LSB first.
- R8: `highz_en` is high exactly while HIGHZ is the current instruction. `clamp_en` is high exactly while CLAMP is the current instruction. The two are never high together.
- R9: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R10: The reconfiguration request is raised in two cases: leaving Update-IR with CONFIG just loaded, or leaving Update-DR while CONFIG is current. Each request drives `cf_n` low for exactly `CF_CYCLES` rising edges of `sys_clk`. At elaboration, `CF_CYCLES`/`SYS_MHZ` must give a pulse between 300 and 500 ns.
- R11: A request that arrives while a pulse is in progress is ignored. The pulse neither restarts nor stretches.
- R12: While `por_n` is low, the controller is held in the reset state, `cf_n` is high and `tdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_clk | input | 1 | Free-running clock that times the reconfiguration pulse |
| isp_active | input | 1 | ISP-mode status for the capture pattern |
| secure_flag | input | 1 | Read-protection status for the capture pattern |
| usercode_val | input | 32 | User-programmable code returned by USERCODE |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| highz_en | output | 1 | Float all device outputs |
| clamp_en | output | 1 | Hold outputs at their preloaded levels |
| cf_n | output | 1 | Active-low reconfiguration pulse to the FPGA |

## Verification
A vector table walks each decoded opcode and one undecoded value. Each entry sets its own combination of the two status inputs, so each captured pattern shows whether bits 4 and 3 follow their own inputs or are swapped or stuck. Bypass-class entries shift in different bit patterns, which distinguishes a correct one-shift delay with a zero first bit from a straight pass-through or a wrong register selection. Directed runs check three things. First, a TMS-only reset after USERCODE, and a power-on reset, both fall back to IDCODE. Second, `tdo` stays stable through the high phase of `tck`. Third, a second CONFIG request inside a running pulse leaves the low time at `CF_CYCLES`, while a request after the pulse produces a fresh one.

// File: rtl/cfgtap_pkg.sv
package cfgtap_pkg;

   localparam int IR_W = 8;
   localparam int DR_W = 32;

   typedef enum logic [3:0] {
      ST_TLR, ST_RTI,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_e;

   typedef enum logic [1:0] {
      PATH_BYP,
      PATH_ID,
      PATH_USER
   } dr_path_e;

   localparam logic [IR_W-1:0] OP_EXTEST   = 8'h00;
   localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h01;
   localparam logic [IR_W-1:0] OP_CLAMP    = 8'hFA;
   localparam logic [IR_W-1:0] OP_HIGHZ    = 8'hFC;
   localparam logic [IR_W-1:0] OP_USERCODE = 8'hFD;
   localparam logic [IR_W-1:0] OP_IDCODE   = 8'hFE;
   localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;
   localparam logic [IR_W-1:0] OP_CONFIG   = 8'hEE;

endpackage

// File: rtl/cfgtap_fsm.sv
module cfgtap_fsm
   import cfgtap_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      unique case (state)
         ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
         ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
         default:   nxt = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state <= ST_TLR;
      else        state <= nxt;
   end

   // R1: five TMS-high edges always land in the reset state
   a_r1_tms_reset: assert property (@(posedge tck) disable iff (!por_n)
      (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> state == ST_TLR);

endmodule

// File: rtl/cfgtap_ir.sv
module cfgtap_ir
   import cfgtap_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  tap_state_e state,
   input  logic       tdi,
   input  logic       isp_active,
   input  logic       secure_flag,
   output logic       ir_lsb,
   output dr_path_e   path,
   output logic       highz_en,
   output logic       clamp_en,
   output logic       req_tgl
);

   logic [IR_W-1:0] ir_sh;
   logic [IR_W-1:0] ir_cur;
   logic            exec_cfg;

   assign exec_cfg = (state == ST_UPD_IR && ir_sh == OP_CONFIG) ||
                     (state == ST_UPD_DR && ir_cur == OP_CONFIG);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         ir_sh   <= '0;
         ir_cur  <= OP_IDCODE;
         req_tgl <= 1'b0;
      end else begin
         if (state == ST_CAP_IR)
            ir_sh <= {3'b000, isp_active, secure_flag, 3'b001};
         else if (state == ST_SH_IR)
            ir_sh <= {tdi, ir_sh[IR_W-1:1]};
         if (state == ST_TLR)
            ir_cur <= OP_IDCODE;
         else if (state == ST_UPD_IR)
            ir_cur <= ir_sh;
         if (exec_cfg)
            req_tgl <= ~req_tgl;
      end
   end

   always_comb begin
      unique case (ir_cur)
         OP_IDCODE:   path = PATH_ID;
         OP_USERCODE: path = PATH_USER;
         default:     path = PATH_BYP;
      endcase
   end

   assign ir_lsb   = ir_sh[0];
   assign highz_en = (ir_cur == OP_HIGHZ);
   assign clamp_en = (ir_cur == OP_CLAMP);

   // R3: capture loads the live status bits into the pattern
   a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!por_n)
      state == ST_CAP_IR |=>
      ir_sh == {3'b000, $past(isp_active), $past(secure_flag), 3'b001});

   // R2: the reset state makes IDCODE current
   a_r2_tlr_idcode: assert property (@(posedge tck) disable iff (!por_n)
      state == ST_TLR |=> path == PATH_ID);

   // R8: float and clamp never requested together
   a_r8_hz_clamp_excl: assert property (@(posedge tck) disable iff (!por_n)
      !(highz_en && clamp_en));

endmodule

// File: rtl/cfgtap_dr.sv
module cfgtap_dr
   import cfgtap_pkg::*;
(
   input  logic            tck,
   input  logic            por_n,
   input  tap_state_e      state,
   input  logic            tdi,
   input  dr_path_e        path,
   input  logic [DR_W-1:0] id_val,
   input  logic [DR_W-1:0] user_val,
   output logic            dr_lsb
);

   logic            byp;
   logic [DR_W-1:0] sh;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         byp <= 1'b0;
         sh  <= '0;
      end else if (state == ST_CAP_DR) begin
         byp <= 1'b0;
         if (path == PATH_ID)        sh <= id_val | DR_W'(1);
         else if (path == PATH_USER) sh <= user_val;
      end else if (state == ST_SH_DR) begin
         byp <= tdi;
         sh  <= {tdi, sh[DR_W-1:1]};
      end
   end

   assign dr_lsb = (path == PATH_BYP) ? byp : sh[0];

   // R5: bypass stage starts every scan at zero
   a_r5_bypass_zero: assert property (@(posedge tck) disable iff (!por_n)
      state == ST_CAP_DR |=> byp == 1'b0);

   // R6: identification code always leaves with bit 0 set
   a_r6_id_lsb_one: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_CAP_DR && path == PATH_ID) |=> sh[0] == 1'b1);

endmodule

// File: rtl/cfgtap_cfpulse.sv
module cfgtap_cfpulse #(
   parameter int CF_CYCLES   = 40,
   parameter int SYNC_STAGES = 2,
   localparam int CW = $clog2(CF_CYCLES + 1)
) (
   input  logic sys_clk,
   input  logic por_n,
   input  logic req_tgl,
   output logic cf_n
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   seen_q;
   logic                   start;
   logic                   busy;
   logic [CW-1:0]          cnt;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge sys_clk or negedge por_n) begin
            if (!por_n) sync_q <= '0;
            else        sync_q <= req_tgl;
         end
      end else begin : g_syncn
         always_ff @(posedge sys_clk or negedge por_n) begin
            if (!por_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], req_tgl};
         end
      end
   endgenerate

   assign start = sync_q[SYNC_STAGES-1] ^ seen_q;

   always_ff @(posedge sys_clk or negedge por_n) begin
      if (!por_n) begin
         seen_q <= 1'b0;
         busy   <= 1'b0;
         cnt    <= '0;
      end else begin
         seen_q <= sync_q[SYNC_STAGES-1];
         if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
         end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(CF_CYCLES - 1);
         end
      end
   end

   assign cf_n = ~busy;

   // checker: length of the current low run
   logic [CW:0] low_run;
   always_ff @(posedge sys_clk or negedge por_n) begin
      if (!por_n)    low_run <= '0;
      else if (busy) low_run <= low_run + 1'b1;
      else           low_run <= '0;
   end

   // R10: every pulse lasts exactly CF_CYCLES clocks
   a_r10_pulse_len: assert property (@(posedge sys_clk) disable iff (!por_n)
      $fell(busy) |-> low_run == (CW+1)'(CF_CYCLES));

   // R11: a request during a pulse does not reload the counter
   a_r11_no_retrigger: assert property (@(posedge sys_clk) disable iff (!por_n)
      (busy && start && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/cfgprom_tap.sv
module cfgprom_tap
   import cfgtap_pkg::*;
#(
   parameter logic [31:0] IDCODE_VAL  = 32'h0500_6093,
   parameter int          SYS_MHZ     = 100,
   parameter int          CF_CYCLES   = 40,
   parameter int          SYNC_STAGES = 2
) (
   input  logic        tck,
   input  logic        tms,
   input  logic        tdi,
   input  logic        por_n,
   input  logic        sys_clk,
   input  logic        isp_active,
   input  logic        secure_flag,
   input  logic [31:0] usercode_val,
   output logic        tdo,
   output logic        tdo_oe,
   output logic        highz_en,
   output logic        clamp_en,
   output logic        cf_n
);

   localparam int PULSE_NS_X = CF_CYCLES * 1000;

   generate
      if (PULSE_NS_X < 300 * SYS_MHZ || PULSE_NS_X > 500 * SYS_MHZ) begin : g_bad_width
         $error("cfgprom_tap: CF_CYCLES/SYS_MHZ outside 300..500 ns");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cfgprom_tap: SYNC_STAGES must be at least 2");
      end
   endgenerate

   tap_state_e state;
   dr_path_e   path;
   logic       ir_lsb;
   logic       dr_lsb;
   logic       req_tgl;

   cfgtap_fsm u_fsm (
      .tck   (tck),
      .por_n (por_n),
      .tms   (tms),
      .state (state)
   );

   cfgtap_ir u_ir (
      .tck         (tck),
      .por_n       (por_n),
      .state       (state),
      .tdi         (tdi),
      .isp_active  (isp_active),
      .secure_flag (secure_flag),
      .ir_lsb      (ir_lsb),
      .path        (path),
      .highz_en    (highz_en),
      .clamp_en    (clamp_en),
      .req_tgl     (req_tgl)
   );

   cfgtap_dr u_dr (
      .tck      (tck),
      .por_n    (por_n),
      .state    (state),
      .tdi      (tdi),
      .path     (path),
      .id_val   (IDCODE_VAL),
      .user_val (usercode_val),
      .dr_lsb   (dr_lsb)
   );

   cfgtap_cfpulse #(
      .CF_CYCLES   (CF_CYCLES),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_cf (
      .sys_clk (sys_clk),
      .por_n   (por_n),
      .req_tgl (req_tgl),
      .cf_n    (cf_n)
   );

   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
         tdo    <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
      end
   end

   // R9: output driven only while a shift state is active
   a_r9_oe_in_shift: assert property (@(posedge tck) disable iff (!por_n)
      tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

   // R12: no pulse pending right after reset release
   a_r12_cf_idle_after_reset: assert property (@(posedge sys_clk) disable iff (!por_n)
      $rose(por_n) |-> cf_n);

endmodule

// File: tb/cfgprom_tap_tb_top.sv
module cfgprom_tap_tb_top;

   localparam logic [31:0] IDV = 32'h0500_6093;
   localparam logic [31:0] UCV = 32'hA5C3_1E77;
   localparam int          NV  = 8;

   // fields: op[81:74] len[73:68] din[67:36] exp[35:4] hz[3] cl[2] isp[1] sec[0]
   localparam logic [81:0] TBL [NV] = '{
      {8'hFE, 6'd32, 32'h0000_0000, IDV,          1'b0, 1'b0, 1'b1, 1'b0},
      {8'hFD, 6'd32, 32'h0000_0000, UCV,          1'b0, 1'b0, 1'b0, 1'b1},
      {8'hFF, 6'd8,  32'h0000_00B2, 32'h0000_0064, 1'b0, 1'b0, 1'b1, 1'b1},
      {8'h55, 6'd8,  32'h0000_003C, 32'h0000_0078, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'hFC, 6'd4,  32'h0000_000F, 32'h0000_000E, 1'b1, 1'b0, 1'b1, 1'b0},
      {8'hFA, 6'd4,  32'h0000_0009, 32'h0000_0002, 1'b0, 1'b1, 1'b0, 1'b1},
      {8'h00, 6'd4,  32'h0000_0005, 32'h0000_000A, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h01, 6'd4,  32'h0000_0006, 32'h0000_000C, 1'b0, 1'b0, 1'b1, 1'b1}
   };

   logic        tck = 1'b0, tms = 1'b1, tdi = 1'b0, por_n = 1'b0, sys_clk = 1'b0;
   logic        isp_active = 1'b0, secure_flag = 1'b0;
   logic [31:0] usercode_val = UCV;
   logic        tdo, tdo_oe, highz_en, clamp_en, cf_n;

   int nchk = 0;
   int nerr = 0;
   int cf_falls = 0;
   int cf_low = 0;
   logic cf_prev = 1'b1;

   cfgprom_tap dut_i (
      .tck(tck), .tms(tms), .tdi(tdi), .por_n(por_n), .sys_clk(sys_clk),
      .isp_active(isp_active), .secure_flag(secure_flag), .usercode_val(usercode_val),
      .tdo(tdo), .tdo_oe(tdo_oe), .highz_en(highz_en), .clamp_en(clamp_en), .cf_n(cf_n)
   );

   always #5 sys_clk = ~sys_clk;

   always @(negedge sys_clk) begin
      if (!cf_n) cf_low <= cf_low + 1;
      if (cf_prev && !cf_n) cf_falls <= cf_falls + 1;
      cf_prev <= cf_n;
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d, output logic o, output logic oe, output logic mid);
      tms = m;
      tdi = d;
      o   = tdo;
      oe  = tdo_oe;
      #20 tck = 1'b1;
      #5  mid = tdo;
      #15 tck = 1'b0;
      #10;
   endtask

   task automatic step(input logic m);
      logic o, oe, mid;
      tick(m, 1'b0, o, oe, mid);
   endtask

   // starts and ends in Run-Test/Idle
   task automatic scan(input bit is_ir, input int len, input logic [31:0] din,
                       output logic [31:0] dout, output bit oe_ok, output bit stable_ok);
      logic o, oe, mid;
      dout = '0;
      oe_ok = 1'b1;
      stable_ok = 1'b1;
      step(1'b1);
      if (is_ir) step(1'b1);
      step(1'b0);
      step(1'b0);
      for (int i = 0; i < len; i++) begin
         tick(i == len - 1, din[i], o, oe, mid);
         dout[i] = o;
         if (!oe) oe_ok = 1'b0;
         if (mid !== o) stable_ok = 1'b0;
      end
      step(1'b1);
      step(1'b0);
   endtask

   initial begin : watchdog
      #3_000_000;
      nchk++;
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin : main
      logic [31:0] dout;
      logic [31:0] msk;
      bit oe_ok, st_ok;

      #100;
      // R12: outputs while reset is held
      check(cf_n === 1'b1 && tdo_oe === 1'b0, "R12 reset outputs", {30'd0, cf_n, tdo_oe}, 32'h2);
      por_n = 1'b1;
      #20;
      check(highz_en === 1'b0 && clamp_en === 1'b0, "R2 reset controls", {30'd0, highz_en, clamp_en}, 32'h0);
      step(1'b0);

      for (int v = 0; v < NV; v++) begin
         logic [81:0] e;
         e = TBL[v];
         isp_active  = e[1];
         secure_flag = e[0];
         scan(1'b1, 8, {24'd0, e[81:74]}, dout, oe_ok, st_ok);
         check(dout[7:0] == {3'b000, e[1], e[0], 3'b001}, "R3 capture pattern",
               dout, {24'd0, 3'b000, e[1], e[0], 3'b001});
         check(highz_en === e[3] && clamp_en === e[2], "R8 output controls",
               {30'd0, highz_en, clamp_en}, {30'd0, e[3], e[2]});
         scan(1'b0, int'(e[73:68]), e[67:36], dout, oe_ok, st_ok);
         msk = (e[73:68] == 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << e[73:68]) - 32'd1);
         if (e[81:74] == 8'hFE)
            check(dout == e[35:4], "R6 idcode scan", dout, e[35:4]);
         else if (e[81:74] == 8'hFD)
            check(dout == e[35:4], "R7 usercode scan", dout, e[35:4]);
         else
            check((dout & msk) == e[35:4], "R4 R5 bypass path", dout & msk, e[35:4]);
         check(oe_ok && st_ok, "R9 oe and falling-edge update", {30'd0, oe_ok, st_ok}, 32'h3);
         check(tdo_oe === 1'b0, "R9 oe low in idle", {31'd0, tdo_oe}, 32'h0);
      end

      // R1 R2: TMS-only reset after selecting USERCODE
      scan(1'b1, 8, 32'hFD, dout, oe_ok, st_ok);
      for (int k = 0; k < 5; k++) step(1'b1);
      step(1'b0);
      scan(1'b0, 32, 32'h0, dout, oe_ok, st_ok);
      check(dout == IDV, "R1 R2 tms reset selects idcode", dout, IDV);

      // R2: HIGHZ dropped by the reset state
      scan(1'b1, 8, 32'hFC, dout, oe_ok, st_ok);
      for (int k = 0; k < 5; k++) step(1'b1);
      check(highz_en === 1'b0, "R2 highz cleared", {31'd0, highz_en}, 32'h0);
      step(1'b0);

      // R12: power-on reset mid-run
      scan(1'b1, 8, 32'hFD, dout, oe_ok, st_ok);
      por_n = 1'b0;
      #30;
      check(cf_n === 1'b1 && tdo_oe === 1'b0, "R12 reset mid-run", {30'd0, cf_n, tdo_oe}, 32'h2);
      por_n = 1'b1;
      #20;
      step(1'b0);
      scan(1'b0, 32, 32'h0, dout, oe_ok, st_ok);
      check(dout == IDV, "R12 idcode after reset", dout, IDV);

      // R10 R11: CONFIG pulse, second request inside the pulse
      check(cf_falls == 0 && cf_n === 1'b1, "R10 no pulse before config", cf_falls, 0);
      scan(1'b1, 8, 32'hEE, dout, oe_ok, st_ok);
      step(1'b1); step(1'b0); step(1'b1); step(1'b1); step(1'b0);
      #1500;
      check(cf_falls == 1, "R11 one pulse for two close requests", cf_falls, 1);
      check(cf_low == 40, "R10 R11 pulse width", cf_low, 40);
      check(cf_n === 1'b1, "R10 cf released", {31'd0, cf_n}, 32'h1);

      // R10: Update-DR re-executes CONFIG after the pulse ended
      step(1'b1); step(1'b0); step(1'b1); step(1'b1); step(1'b0);
      #1500;
      check(cf_falls == 2, "R10 second pulse", cf_falls, 2);
      check(cf_low == 80, "R10 second pulse width", cf_low, 80);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule